// File: doc/BRIEF.md
# Timing Signal Crossbar

This block routes timing signals between a set of external bidirectional pins and the internal logic that produces and consumes them. Each internal consumer has its own select register that names the pin it listens to. Any consumer may pick any pin, and several consumers may listen to one pin at once. Each pin has a drive register that holds an output-enable bit and the index of the internal signal to drive. When the enable bit is set, the pin drives that signal.

Every routed consumer input passes through a two-flop synchronizer after its multiplexer, so pins that are asynchronous to the block clock can feed synchronous logic safely. The pin output and output-enable are registered. A pin that is driving feeds its own driven value back to the consumers that select it, so the internal loop does not depend on the pad. The default parameters give a ten-pin matrix with 4-bit selects. A second instance with seven lines, eight signals and 3-bit selects serves an inter-board trigger bus.

Top module: `trig_xbar`

## Requirements
- R1: While reset is high and after it is released, with no writes made, pin_oe, pin_out and cons_out are all zero. Every consumer select resets to the all-ones code and every pin drive register resets to disabled.
- R2: A write happens on a rising clock edge when wr_en is high. wr_addr bit IW chooses the bank (0 = consumer select, 1 = pin drive) and wr_addr[IW-1:0] is the index. A consumer write takes its code from wr_data[SEL_W-1:0]. A pin write takes the enable from wr_data[DRV_W] and the signal index from wr_data[DRV_W-1:0].
- R3: A consumer whose select code k is below NUM_PINS follows pin k through two flops. A level on the pin before clock edge n appears on cons_out after edge n+1.
- R4: Select codes from NUM_PINS up to 2^SEL_W-1 drive a constant 0 into the consumer.
- R5: Any number of consumers may select the same pin at the same time, and each of them sees that pin's level.
- R6: A pin whose drive register is enabled with signal index s raises pin_oe and drives sig_in[s] on pin_out through one register. Both outputs take effect one clock after the write edge.
- R7: A pin whose drive register is disabled holds pin_oe and pin_out at 0 whatever sig_in does.
- R8: While a pin is driving, consumers that select it see its pin_out value, and pin_in for that pin has no effect.
- R9: A write whose index is not below the bank's entry count (NUM_CONS or NUM_PINS) changes no register. A write in range changes only the addressed register.
- R10: With NUM_PINS=7 and NUM_SIGS=8, both select fields are 3 bits wide. Code 7 is then the consumer "none" code, and all eight signals can be driven onto any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (5) | Bank bit on top, entry index below |
| wr_data | input | DW (5) | Write data: select code, or enable plus signal index |
| sig_in | input | NUM_SIGS (16) | Internal timing signals available for driving out |
| pin_in | input | NUM_PINS (10) | Levels received from the pins |
| pin_out | output | NUM_PINS (10) | Registered drive value per pin |
| pin_oe | output | NUM_PINS (10) | Registered output enable per pin |
| cons_out | output | NUM_CONS (12) | Synchronized routed input per consumer |

## Verification
A corrupted consumer select makes the wrong pin's level, or a stuck zero, appear on cons_out two clocks after the pins change. The sweeps set pin levels so that each wrong pin gives a visible difference. A wrong drive register shows on pin_oe and pin_out one clock after the write or the signal change. A broken feedback path shows on cons_out three clocks after the driving signal toggles against the opposite pin_in level. A write that leaks past the range check shows as a spurious enable or a new route within three clocks.

// File: rtl/trig_xbar_pkg.sv
package trig_xbar_pkg;

  typedef enum logic {
    BANK_CONS = 1'b0,
    BANK_PIN  = 1'b1
  } bank_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/trig_xbar_cfg.sv
module trig_xbar_cfg
  import trig_xbar_pkg::*;
#(
  parameter int NUM_PINS = 10,
  parameter int NUM_CONS = 12,
  parameter int SEL_W    = 4,
  parameter int DRV_W    = 4,
  parameter int DW       = 5,
  parameter int IW       = 4
)(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [IW:0]                    wr_addr,
  input  logic [DW-1:0]                  wr_data,
  output logic [NUM_CONS-1:0][SEL_W-1:0] cons_sel,
  output logic [NUM_PINS-1:0]            pin_en,
  output logic [NUM_PINS-1:0][DRV_W-1:0] pin_sel
);

  bank_e         bank;
  logic [IW-1:0] idx;

  assign bank = bank_e'(wr_addr[IW]);
  assign idx  = wr_addr[IW-1:0];

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
    always_ff @(posedge clk) begin
      if (rst) begin
        cons_sel[c] <= '1;
      end else if (wr_en && bank == BANK_CONS && idx == IW'(c)) begin
        cons_sel[c] <= wr_data[SEL_W-1:0];
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_en[p]  <= 1'b0;
        pin_sel[p] <= '0;
      end else if (wr_en && bank == BANK_PIN && idx == IW'(p)) begin
        pin_en[p]  <= wr_data[DRV_W];
        pin_sel[p] <= wr_data[DRV_W-1:0];
      end
    end
  end

  // R9: a write outside the bank's range leaves every register untouched
  assert_oob_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ((bank == BANK_CONS && 32'(idx) >= NUM_CONS) ||
               (bank == BANK_PIN  && 32'(idx) >= NUM_PINS)))
    |=> ($stable(cons_sel) && $stable(pin_en) && $stable(pin_sel)));

  // R2: an in-range pin write lands its enable bit in the addressed entry
  assert_pin_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bank == BANK_PIN && 32'(idx) < NUM_PINS)
    |=> (pin_en[$past(idx)] == $past(wr_data[DRV_W])));

endmodule

// File: rtl/trig_xbar_drive.sv
module trig_xbar_drive #(
  parameter int NUM_PINS = 10,
  parameter int NUM_SIGS = 16,
  parameter int DRV_W    = 4
)(
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_SIGS-1:0]            sig_in,
  input  logic [NUM_PINS-1:0]            pin_en,
  input  logic [NUM_PINS-1:0][DRV_W-1:0] pin_sel,
  output logic [NUM_PINS-1:0]            pin_out,
  output logic [NUM_PINS-1:0]            pin_oe
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic pick;
    logic out_q;
    logic oe_q;

    always_comb begin
      pick = 1'b0;
      for (int s = 0; s < NUM_SIGS; s++) begin
        if (pin_sel[p] == DRV_W'(s)) pick = sig_in[s];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q <= 1'b0;
        oe_q  <= 1'b0;
      end else begin
        oe_q  <= pin_en[p];
        out_q <= pin_en[p] & pick;
      end
    end

    assign pin_out[p] = out_q;
    assign pin_oe[p]  = oe_q;

    // R7: an undriven pin never shows a high output value
    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (rst)
      !oe_q |-> !out_q);

    // R6: an enabled pin carries the selected signal one clock later
    assert_follow_sig_R6: assert property (@(posedge clk) disable iff (rst)
      pin_en[p] |=> (out_q == $past(sig_in[pin_sel[p]])));
  end

endmodule

// File: rtl/trig_xbar_route.sv
module trig_xbar_route #(
  parameter int NUM_PINS = 10,
  parameter int NUM_CONS = 12,
  parameter int SEL_W    = 4
)(
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PINS-1:0]            pin_fb,
  input  logic [NUM_CONS-1:0][SEL_W-1:0] cons_sel,
  output logic [NUM_CONS-1:0]            cons_out
);

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
    logic pick;
    logic s1;
    logic s2;

    always_comb begin
      pick = 1'b0;
      for (int k = 0; k < NUM_PINS; k++) begin
        if (cons_sel[c] == SEL_W'(k)) pick = pin_fb[k];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= pick;
        s2 <= s1;
      end
    end

    assign cons_out[c] = s2;

    // R4: codes past the last pin feed a zero into the synchronizer
    assert_none_code_R4: assert property (@(posedge clk) disable iff (rst)
      (cons_sel[c] >= SEL_W'(NUM_PINS)) |=> (s1 == 1'b0));

    // R3: an in-range code samples the chosen pin into the first stage
    assert_pin_sampled_R3: assert property (@(posedge clk) disable iff (rst)
      (cons_sel[c] < SEL_W'(NUM_PINS)) |=> (s1 == $past(pin_fb[cons_sel[c]])));
  end

endmodule

// File: rtl/trig_xbar.sv
module trig_xbar
  import trig_xbar_pkg::*;
#(
  parameter int NUM_PINS = 10,
  parameter int NUM_SIGS = 16,
  parameter int NUM_CONS = 12,
  localparam int SEL_W = $clog2(NUM_PINS + 1),
  localparam int DRV_W = (NUM_SIGS > 1) ? $clog2(NUM_SIGS) : 1,
  localparam int DW    = max2(SEL_W, DRV_W + 1),
  localparam int NMAX  = max2(NUM_CONS, NUM_PINS),
  localparam int IW    = (NMAX > 1) ? $clog2(NMAX) : 1,
  localparam int AW    = IW + 1
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [NUM_SIGS-1:0] sig_in,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_CONS-1:0] cons_out
);

  logic [NUM_CONS-1:0][SEL_W-1:0] cons_sel;
  logic [NUM_PINS-1:0]            pin_en;
  logic [NUM_PINS-1:0][DRV_W-1:0] pin_sel;
  logic [NUM_PINS-1:0]            pin_fb;

  trig_xbar_cfg #(
    .NUM_PINS(NUM_PINS), .NUM_CONS(NUM_CONS), .SEL_W(SEL_W),
    .DRV_W(DRV_W), .DW(DW), .IW(IW)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cons_sel(cons_sel), .pin_en(pin_en), .pin_sel(pin_sel)
  );

  trig_xbar_drive #(
    .NUM_PINS(NUM_PINS), .NUM_SIGS(NUM_SIGS), .DRV_W(DRV_W)
  ) u_drive (
    .clk(clk), .rst(rst), .sig_in(sig_in), .pin_en(pin_en), .pin_sel(pin_sel),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // a driving pin loops its own output back, otherwise the received level
  assign pin_fb = (pin_oe & pin_out) | (~pin_oe & pin_in);

  trig_xbar_route #(
    .NUM_PINS(NUM_PINS), .NUM_CONS(NUM_CONS), .SEL_W(SEL_W)
  ) u_route (
    .clk(clk), .rst(rst), .pin_fb(pin_fb), .cons_sel(cons_sel), .cons_out(cons_out)
  );

  // R1: outputs are quiet on the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_oe == '0 && pin_out == '0 && cons_out == '0));

endmodule

// File: tb/test_trig_xbar.sv
`timescale 1ns/1ps
module test_trig_xbar;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int vecs  = 0;
  int fails = 0;
  bit done  = 1'b0;

  // ---------------- default instance: 10 pins, 16 signals, 12 consumers
  logic        a_wen = 1'b0;
  logic [4:0]  a_addr = '0;
  logic [4:0]  a_data = '0;
  logic [15:0] sig_a = '0;
  logic [9:0]  pin_a = '0;
  logic [9:0]  a_pout, a_poe;
  logic [11:0] a_cons;

  trig_xbar i_trig_xbar (
    .clk(clk), .rst(rst), .wr_en(a_wen), .wr_addr(a_addr), .wr_data(a_data),
    .sig_in(sig_a), .pin_in(pin_a), .pin_out(a_pout), .pin_oe(a_poe), .cons_out(a_cons)
  );

  int csel_a [12];
  bit oe_a   [10];
  int dsel_a [10];

  // ---------------- bus instance: 7 lines, 8 signals, 8 consumers (R10)
  logic       b_wen = 1'b0;
  logic [3:0] b_addr = '0;
  logic [3:0] b_data = '0;
  logic [7:0] sig_b = '0;
  logic [6:0] pin_b = '0;
  logic [6:0] b_pout, b_poe;
  logic [7:0] b_cons;

  trig_xbar #(.NUM_PINS(7), .NUM_SIGS(8), .NUM_CONS(8)) i_trig_xbar_bus (
    .clk(clk), .rst(rst), .wr_en(b_wen), .wr_addr(b_addr), .wr_data(b_data),
    .sig_in(sig_b), .pin_in(pin_b), .pin_out(b_pout), .pin_oe(b_poe), .cons_out(b_cons)
  );

  int csel_b [8];
  bit oe_b   [7];
  int dsel_b [7];

  // R2: bank bit on top of the address, enable at data bit DRV_W
  task automatic wr_a(input int bank, input int idx, input int data);
    @(negedge clk);
    a_wen = 1'b1; a_addr = 5'((bank << 4) | idx); a_data = 5'(data);
    @(negedge clk);
    a_wen = 1'b0;
    if (bank == 0 && idx < 12) csel_a[idx] = data & 15;
    if (bank == 1 && idx < 10) begin oe_a[idx] = ((data >> 4) & 1) != 0; dsel_a[idx] = data & 15; end
  endtask

  task automatic wr_b(input int bank, input int idx, input int data);
    @(negedge clk);
    b_wen = 1'b1; b_addr = 4'((bank << 3) | idx); b_data = 4'(data);
    @(negedge clk);
    b_wen = 1'b0;
    if (bank == 0 && idx < 8) csel_b[idx] = data & 7;
    if (bank == 1 && idx < 7) begin oe_b[idx] = ((data >> 3) & 1) != 0; dsel_b[idx] = data & 7; end
  endtask

  task automatic check_a(input string tag);
    logic [9:0]  eo, eout, fb;
    logic [11:0] ec;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 10; p++) begin
      eo[p]   = oe_a[p];
      eout[p] = oe_a[p] & sig_a[dsel_a[p]];
      fb[p]   = oe_a[p] ? sig_a[dsel_a[p]] : pin_a[p];
    end
    for (int c = 0; c < 12; c++) ec[c] = (csel_a[c] < 10) ? fb[csel_a[c]] : 1'b0;
    vecs++;
    if (a_poe !== eo || a_pout !== eout || a_cons !== ec) begin
      fails++;
      $display("FAIL %s: oe=%h out=%h cons=%h expected oe=%h out=%h cons=%h",
               tag, a_poe, a_pout, a_cons, eo, eout, ec);
    end
  endtask

  task automatic check_b(input string tag);
    logic [6:0] eo, eout, fb;
    logic [7:0] ec;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 7; p++) begin
      eo[p]   = oe_b[p];
      eout[p] = oe_b[p] & sig_b[dsel_b[p]];
      fb[p]   = oe_b[p] ? sig_b[dsel_b[p]] : pin_b[p];
    end
    for (int c = 0; c < 8; c++) ec[c] = (csel_b[c] < 7) ? fb[csel_b[c]] : 1'b0;
    vecs++;
    if (b_poe !== eo || b_pout !== eout || b_cons !== ec) begin
      fails++;
      $display("FAIL %s: oe=%h out=%h cons=%h expected oe=%h out=%h cons=%h",
               tag, b_poe, b_pout, b_cons, eo, eout, ec);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      report();
    end
  end

  initial begin
    for (int c = 0; c < 12; c++) csel_a[c] = 15;
    for (int p = 0; p < 10; p++) begin oe_a[p] = 1'b0; dsel_a[p] = 0; end
    for (int c = 0; c < 8; c++) csel_b[c] = 7;
    for (int p = 0; p < 7; p++) begin oe_b[p] = 1'b0; dsel_b[p] = 0; end

    repeat (4) @(negedge clk);
    pin_a = '1; sig_a = '1; pin_b = '1; sig_b = '1;
    @(negedge clk);
    // R1: outputs stay zero during reset even with all inputs high
    vecs++;
    if (a_poe !== '0 || a_pout !== '0 || a_cons !== '0) begin
      fails++;
      $display("FAIL R1 in reset: oe=%h out=%h cons=%h expected all 0", a_poe, a_pout, a_cons);
    end
    rst = 1'b0;
    check_a("R1 after reset");
    check_b("R1 bus after reset");

    // R5, R3: every consumer on one pin, pin toggled against its neighbours
    for (int p = 0; p < 10; p++) begin
      for (int c = 0; c < 12; c++) wr_a(0, c, p);
      pin_a = 10'(1 << p);
      check_a("R5 shared pin high");
      pin_a = ~10'(1 << p);
      check_a("R5 shared pin low");
    end

    // R3: scattered selects under many pin patterns
    for (int c = 0; c < 12; c++) wr_a(0, c, (c * 7 + 3) % 10);
    for (int t = 0; t < 16; t++) begin
      pin_a = 10'((t * 613 + 341) & 1023);
      check_a("R3 scattered routes");
    end

    // R4: all unused codes read as zero with every pin high
    for (int c = 0; c < 12; c++) wr_a(0, c, 10 + (c % 6));
    pin_a = '1;
    check_a("R4 none codes");

    // R6, R7: each pin drives each signal, then is switched off
    for (int p = 0; p < 10; p++) begin
      for (int s = 0; s < 16; s++) begin
        wr_a(1, p, 16 | s);
        sig_a = 16'(1 << s);
        check_a("R6 drive high");
        sig_a = ~16'(1 << s);
        check_a("R6 drive low");
        wr_a(1, p, s);
        sig_a = '1;
        check_a("R7 disabled pin");
      end
    end

    // R8: driven pin 4 loops back; pin 5 stays an input
    wr_a(1, 4, 16 | 9);
    for (int c = 0; c < 12; c++) wr_a(0, c, (c % 2 == 0) ? 4 : 5);
    for (int t = 0; t < 8; t++) begin
      sig_a = (t & 1) ? 16'h0200 : 16'h0000;
      pin_a = 10'(((t >> 1) & 1) << 4 | ((t >> 2) & 1) << 5);
      check_a("R8 feedback");
    end
    wr_a(1, 4, 0);

    // R9: out-of-range writes must neither route nor enable anything
    for (int c = 0; c < 12; c++) wr_a(0, c, 15);
    pin_a = 10'h001; sig_a = 16'h0001;
    for (int i = 12; i < 16; i++) begin
      wr_a(0, i, 0);
      check_a("R9 cons index out of range");
    end
    for (int i = 10; i < 16; i++) begin
      wr_a(1, i, 16);
      check_a("R9 pin index out of range");
    end
    wr_a(0, 3, 0);
    check_a("R9 single in-range write");

    // R10: narrow bus instance
    for (int p = 0; p < 7; p++) begin
      for (int c = 0; c < 8; c++) wr_b(0, c, p);
      pin_b = 7'(1 << p);
      check_b("R10 bus shared line high");
      pin_b = ~7'(1 << p);
      check_b("R10 bus shared line low");
    end
    for (int c = 0; c < 8; c++) wr_b(0, c, 7);
    pin_b = '1;
    check_b("R10 bus none code 7");
    for (int p = 0; p < 7; p++) begin
      for (int s = 0; s < 8; s++) begin
        wr_b(1, p, 8 | s);
        sig_b = 8'(1 << s);
        check_b("R10 bus drive high");
        sig_b = ~8'(1 << s);
        check_b("R10 bus drive low");
        wr_b(1, p, s);
      end
    end
    check_b("R10 bus all lines released");

    done = 1'b1;
    report();
  end

endmodule